// File: doc/BRIEF.md
# Block Memory Copy/Compare Engine

This execution unit carries out the four block-memory instructions of a small 8-bit processor: copy-and-step-up, copy-and-step-down, compare-and-step-up and compare-and-step-down. The register file hands it four bytes, a, x, b and y. The 16-bit value {a,x} is the source pointer and {b,y} is the destination pointer. In both pointers the first register is the high byte.

A copy moves the source byte to the destination address. A compare subtracts the destination byte from the source byte, keeps the four condition flags and throws the difference away. Every instruction then moves both pointers by one, either up or down, and hands back the new a, x, b and y values together with a done pulse. The engine takes four clock cycles per instruction, where a normal instruction takes one. It drives a single-port byte memory whose read data arrives one cycle after the address.

Top module: `blkmem_engine`

## Requirements
- R1: While rst_n is low, and on the first cycle after it, busy, done, mem_we and flags_we are 0 and flags_out is 4'b0000.
- R2: A start seen while idle makes busy high for exactly four cycles, the start cycle not counted. done is high only in the fourth of those cycles, and busy is low on the following cycle.
- R3: In the first busy cycle the engine reads the source: mem_addr equals {a_in,x_in} as captured at start, and mem_we is 0.
- R4: For a copy (op[1]=0), the second busy cycle has mem_we=1, mem_addr={b_in,y_in} and mem_wdata equal to the byte at the source address, so the destination now holds that byte.
- R5: For a compare (op[1]=1), mem_we stays 0 in every cycle of the instruction, and mem_addr is {b_in,y_in} in the second busy cycle.
- R6: A compare computes source byte minus destination byte. In the done cycle it drives flags_we=1 and flags_out = {Z,C,O,S}. Z (bit 3) is 1 when the difference is zero. C (bit 2) is 1 when the source is below the destination as unsigned values. O (bit 1) is signed overflow of the 8-bit subtract. S (bit 0) is bit 7 of the difference.
- R7: With op[0]=0, the done cycle shows {a_out,x_out}={a,x}+1 and {b_out,y_out}={b,y}+1. A carry out of the low byte increments the high byte, and 16'hFFFF wraps to 16'h0000.
- R8: With op[0]=1, the done cycle shows both pointers minus 1. A borrow out of the low byte decrements the high byte, and 16'h0000 wraps to 16'hFFFF.
- R9: The two pointers step independently. A carry or borrow in x changes only a, and one in y changes only b.
- R10: A copy leaves flags_out unchanged and keeps flags_we at 0 in its done cycle. Stepping the pointers never alters flags_out.
- R11: A start raised while busy is ignored. No extra instruction runs, and no second done pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction (taken only while idle) |
| op | input | 2 | Bit 1: 1 = compare, 0 = copy; bit 0: 1 = step down, 0 = step up |
| a_in | input | 8 | Source pointer high byte |
| x_in | input | 8 | Source pointer low byte |
| b_in | input | 8 | Destination pointer high byte |
| y_in | input | 8 | Destination pointer low byte |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse; pointer outputs valid |
| a_out | output | 8 | Updated a |
| x_out | output | 8 | Updated x |
| b_out | output | 8 | Updated b |
| y_out | output | 8 | Updated y |
| flags_we | output | 1 | Flags update strobe (compare only, in done cycle) |
| flags_out | output | 4 | {Z,C,O,S} from the last compare |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after address |

## Verification
Counting from the clock edge that accepts start, the source read address appears in the first cycle. The destination address, and for a copy the write, follow in the second cycle. Flags, updated pointers and done all land in the fourth cycle, and busy drops in the fifth. The driver raises start just after a falling edge and checks each slot at the falling edge that follows. The monitor pops the expected pointers and flags at the falling edge where done is high. An injected start inside the window is checked by confirming that busy drops on time and that no unmatched done appears.

// File: rtl/blkmem_pkg.sv
package blkmem_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_SRC  = 3'd1,
        ST_DST  = 3'd2,
        ST_FLG  = 3'd3,
        ST_WB   = 3'd4
    } eng_state_e;

    typedef struct packed {
        logic z;
        logic c;
        logic o;
        logic s;
    } cond_flags_t;

endpackage

// File: rtl/blkmem_ptr_step.sv
module blkmem_ptr_step #(
    parameter int HALF_W = 8
) (
    input  logic                  dec,
    input  logic [2*HALF_W-1:0]   cur,
    output logic [2*HALF_W-1:0]   nxt
);
    localparam int PTR_W = 2 * HALF_W;

    logic [HALF_W-1:0] lo_cur, hi_cur, lo_nxt, hi_nxt;
    logic              chain;

    assign lo_cur = cur[HALF_W-1:0];
    assign hi_cur = cur[PTR_W-1:HALF_W];

    always_comb begin
        if (dec) begin
            chain  = (lo_cur == '0);
            lo_nxt = lo_cur - {{(HALF_W-1){1'b0}}, 1'b1};
            hi_nxt = hi_cur - {{(HALF_W-1){1'b0}}, chain};
        end else begin
            chain  = (lo_cur == '1);
            lo_nxt = lo_cur + {{(HALF_W-1){1'b0}}, 1'b1};
            hi_nxt = hi_cur + {{(HALF_W-1){1'b0}}, chain};
        end
    end

    assign nxt = {hi_nxt, lo_nxt};

endmodule

// File: rtl/blkmem_flag_calc.sv
module blkmem_flag_calc
    import blkmem_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output cond_flags_t  flg
);
    logic [W:0] diff_ext;

    always_comb begin
        diff_ext = {1'b0, lhs} - {1'b0, rhs};
        flg.z    = (diff_ext[W-1:0] == '0);
        flg.c    = diff_ext[W];
        flg.o    = (lhs[W-1] != rhs[W-1]) && (diff_ext[W-1] != lhs[W-1]);
        flg.s    = diff_ext[W-1];
    end

endmodule

// File: rtl/blkmem_engine.sv
module blkmem_engine
    import blkmem_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [1:0]            op,
    input  logic [DATA_W-1:0]     a_in,
    input  logic [DATA_W-1:0]     x_in,
    input  logic [DATA_W-1:0]     b_in,
    input  logic [DATA_W-1:0]     y_in,
    output logic                  busy,
    output logic                  done,
    output logic [DATA_W-1:0]     a_out,
    output logic [DATA_W-1:0]     x_out,
    output logic [DATA_W-1:0]     b_out,
    output logic [DATA_W-1:0]     y_out,
    output logic                  flags_we,
    output logic [3:0]            flags_out,
    output logic [2*DATA_W-1:0]   mem_addr,
    output logic                  mem_we,
    output logic [DATA_W-1:0]     mem_wdata,
    input  logic [DATA_W-1:0]     mem_rdata
);
    localparam int PTR_W  = 2 * DATA_W;
    localparam int N_PTRS = 2;

    typedef struct packed {
        eng_state_e          st;
        logic                cmp;
        logic                dec;
        logic [PTR_W-1:0]    src;
        logic [PTR_W-1:0]    dst;
        logic [DATA_W-1:0]   sbyte;
        cond_flags_t         flg;
    } eng_regs_t;

    eng_regs_t   r_d, r_q;
    cond_flags_t flg_new;

    logic [PTR_W-1:0] ptr_cur [N_PTRS];
    logic [PTR_W-1:0] ptr_nxt [N_PTRS];

    assign ptr_cur[0] = r_q.src;
    assign ptr_cur[1] = r_q.dst;

    for (genvar gi = 0; gi < N_PTRS; gi++) begin : g_step
        blkmem_ptr_step #(.HALF_W(DATA_W)) u_step (
            .dec (r_q.dec),
            .cur (ptr_cur[gi]),
            .nxt (ptr_nxt[gi])
        );
    end

    blkmem_flag_calc #(.W(DATA_W)) u_flags (
        .lhs (r_q.sbyte),
        .rhs (mem_rdata),
        .flg (flg_new)
    );

    always_comb begin
        r_d       = r_q;
        mem_addr  = r_q.src;
        mem_we    = 1'b0;
        mem_wdata = mem_rdata;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st  = ST_SRC;
                    r_d.cmp = op[1];
                    r_d.dec = op[0];
                    r_d.src = {a_in, x_in};
                    r_d.dst = {b_in, y_in};
                end
            end
            ST_SRC: begin
                mem_addr = r_q.src;
                r_d.st   = ST_DST;
            end
            ST_DST: begin
                mem_addr  = r_q.dst;
                mem_we    = !r_q.cmp;
                r_d.sbyte = mem_rdata;
                r_d.st    = ST_FLG;
            end
            ST_FLG: begin
                mem_addr = r_q.dst;
                if (r_q.cmp) begin
                    r_d.flg = flg_new;
                end
                r_d.st = ST_WB;
            end
            ST_WB: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st != ST_IDLE);
    assign done      = (r_q.st == ST_WB);
    assign flags_we  = done && r_q.cmp;
    assign flags_out = r_q.flg;
    assign a_out     = ptr_nxt[0][PTR_W-1:DATA_W];
    assign x_out     = ptr_nxt[0][DATA_W-1:0];
    assign b_out     = ptr_nxt[1][PTR_W-1:DATA_W];
    assign y_out     = ptr_nxt[1][DATA_W-1:0];

endmodule

// File: rtl/blkmem_engine_chk.sv
module blkmem_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [1:0] op,
    input logic       busy,
    input logic       done,
    input logic       mem_we,
    input logic       flags_we,
    input logic [3:0] flags_out
);
    logic [2:0] busy_cnt;
    logic       cmp_lat;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= '0;
            cmp_lat  <= 1'b0;
        end else begin
            if (busy) begin
                busy_cnt <= (busy_cnt == 3'd7) ? busy_cnt : busy_cnt + 3'd1;
            end else begin
                busy_cnt <= '0;
            end
            if (start && !busy) begin
                cmp_lat <= op[1];
            end
        end
    end

    a_r2_done_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r2_done_fourth_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_cnt == 3'd3));

    a_r2_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    a_r4_write_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    a_r5_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmp_lat) |-> !mem_we);

    a_r6_flags_we_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we |-> (done && cmp_lat));

    a_r10_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_out != $past(flags_out)) |-> (busy && cmp_lat));

endmodule

bind blkmem_engine blkmem_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op        (op),
    .busy      (busy),
    .done      (done),
    .mem_we    (mem_we),
    .flags_we  (flags_we),
    .flags_out (flags_out)
);

// File: tb/tb_blkmem_engine.sv
`timescale 1ns/1ps
module tb_blkmem_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [7:0]  a_in = '0, x_in = '0, b_in = '0, y_in = '0;
    logic        busy, done, flags_we, mem_we;
    logic [7:0]  a_out, x_out, b_out, y_out, mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic [3:0]  flags_out;
    logic [15:0] mem_addr;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    blkmem_engine dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .a_in(a_in), .x_in(x_in), .b_in(b_in), .y_in(y_in),
        .busy(busy), .done(done),
        .a_out(a_out), .x_out(x_out), .b_out(b_out), .y_out(y_out),
        .flags_we(flags_we), .flags_out(flags_out),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    // sparse byte memory, registered read
    logic [7:0] mem [int];

    function automatic logic [7:0] peek(input logic [15:0] ad);
        return mem.exists(int'(ad)) ? mem[int'(ad)] : 8'h00;
    endfunction

    always @(posedge clk) begin
        mem_rdata <= peek(mem_addr);
        if (mem_we) mem[int'(mem_addr)] = mem_wdata;
    end

    typedef struct {
        logic [15:0] src_n;
        logic [15:0] dst_n;
        logic        fwe;
        logic [3:0]  flg;
        string       tag;
    } exp_t;

    exp_t sb[$];
    logic [3:0] last_flags = 4'b0000;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] step(input logic [15:0] p, input bit dn);
        return dn ? p - 16'd1 : p + 16'd1;
    endfunction

    function automatic logic [3:0] ref_flags(input logic [7:0] s, input logic [7:0] t);
        logic [7:0] d;
        d = s - t;
        return {d == 8'h00, s < t, (s[7] != t[7]) && (d[7] != s[7]), d[7]};
    endfunction

    // monitor: pops expected results in the done cycle
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R11", "unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk({a_out, x_out} == e.src_n, e.tag, "src pointer", {a_out, x_out}, e.src_n);
                chk({b_out, y_out} == e.dst_n, e.tag, "dst pointer", {b_out, y_out}, e.dst_n);
                chk(flags_we == e.fwe, e.fwe ? "R6" : "R10", "flags_we", flags_we, e.fwe);
                chk(flags_out == e.flg, e.fwe ? "R6" : "R10", "flags_out", flags_out, e.flg);
            end
        end
    end

    // driver: issues one instruction and checks each slot
    task automatic issue(input logic [1:0] o, input logic [7:0] a, input logic [7:0] x,
                         input logic [7:0] b, input logic [7:0] y, input string tag,
                         input bit inject);
        exp_t e;
        logic [15:0] sp, dp;
        logic [7:0]  sbyte, dbyte;
        sp = {a, x};
        dp = {b, y};
        sbyte = peek(sp);
        dbyte = peek(dp);
        e.src_n = step(sp, o[0]);
        e.dst_n = step(dp, o[0]);
        e.fwe   = o[1];
        if (o[1]) last_flags = ref_flags(sbyte, dbyte);
        e.flg   = last_flags;
        e.tag   = tag;
        sb.push_back(e);

        @(negedge clk);
        op = o; a_in = a; x_in = x; b_in = b; y_in = y; start = 1'b1;
        @(negedge clk);                       // busy cycle 1
        start = inject;
        if (inject) op = ~o;
        chk(busy == 1'b1, "R2", "busy cycle1", busy, 1);
        chk(mem_addr == sp, "R3", "source addr", mem_addr, sp);
        chk(mem_we == 1'b0, "R3", "no write on read", mem_we, 0);
        @(negedge clk);                       // busy cycle 2
        start = 1'b0;
        chk(mem_addr == dp, o[1] ? "R5" : "R4", "dest addr", mem_addr, dp);
        chk(mem_we == !o[1], o[1] ? "R5" : "R4", "write enable", mem_we, !o[1]);
        if (!o[1]) chk(mem_wdata == sbyte, "R4", "write data", mem_wdata, sbyte);
        @(negedge clk);                       // busy cycle 3
        chk(busy == 1'b1 && done == 1'b0, "R2", "cycle3 busy/done", {busy, done}, 2'b10);
        if (o[1]) chk(mem_we == 1'b0, "R5", "no write cycle3", mem_we, 0);
        @(negedge clk);                       // busy cycle 4: monitor checks done
        chk(done == 1'b1, "R2", "done cycle4", done, 1);
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, inject ? "R11" : "R2", "idle after done",
            {busy, done}, 2'b00);
        if (!o[1]) chk(peek(dp) == sbyte, "R4", "dest holds copy", peek(dp), sbyte);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && mem_we == 0 && flags_we == 0 && flags_out == 0,
            "R1", "reset outputs", {busy, done, mem_we, flags_we, flags_out}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && done == 0 && flags_out == 0, "R1", "after reset",
            {busy, done, flags_out}, 0);

        mem[16'h1234] = 8'hA5;
        mem[16'h2000] = 8'h3C; mem[16'h3000] = 8'h3C;
        mem[16'h2100] = 8'h10; mem[16'h3100] = 8'h20;
        mem[16'h2200] = 8'h80; mem[16'h3200] = 8'h01;
        mem[16'h2300] = 8'h7F; mem[16'h3300] = 8'h80;
        mem[16'h4000] = 8'h5A;

        issue(2'b00, 8'h12, 8'h34, 8'h56, 8'h78, "R4 R7 copy-up", 1'b0);
        issue(2'b10, 8'h20, 8'h00, 8'h30, 8'h00, "R6 cmp-equal", 1'b0);
        issue(2'b11, 8'h21, 8'h00, 8'h31, 8'h00, "R6 R8 cmp-below", 1'b0);
        issue(2'b10, 8'h22, 8'h00, 8'h32, 8'h00, "R6 cmp-ovf", 1'b0);
        issue(2'b00, 8'h12, 8'hFF, 8'h56, 8'h00, "R9 carry-x-only", 1'b0);
        issue(2'b00, 8'h56, 8'h00, 8'h12, 8'hFF, "R9 carry-y-only", 1'b0);
        issue(2'b10, 8'hFF, 8'hFF, 8'hFF, 8'hFF, "R7 wrap-up", 1'b0);
        issue(2'b01, 8'h12, 8'h00, 8'h00, 8'h00, "R8 borrow-wrap-down", 1'b0);
        issue(2'b01, 8'h40, 8'h00, 8'h41, 8'h00, "R10 copy-keeps-flags", 1'b0);
        issue(2'b10, 8'h23, 8'h00, 8'h33, 8'h00, "R6 cmp-neg-ovf", 1'b1);
        issue(2'b00, 8'h12, 8'h34, 8'h77, 8'h77, "R11 copy-after-inject", 1'b1);

        repeat (4) @(negedge clk);
        chk(sb.size() == 0, "R11", "pending results", sb.size(), 0);
        chk(busy == 1'b0, "R11", "stays idle", busy, 0);

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule